// File: doc/BRIEF.md
# Vectored Level Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and presents a single request line to a processor. Each line is gated by its own configuration word. The 7-bit field in that word must hold one exact enable code before the line can take part in arbitration. Any other value, including the reset value of zero, keeps the line out.

Arbitration reports the lowest-numbered line that is both enabled and asserted. The result appears in one read-only select word that packs a pending flag with the line number. The request output mirrors that pending flag.

Software reaches the configuration words and the select word through a plain register port: byte address, write data, write strobe and combinational read data. A build parameter picks one of two flavors. The flavors differ in the enable code and in the address of the select word. Secondary aggregators, if present, connect as ordinary input lines.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every configuration field reads 0x00, the select word reads 0 and `cpu_irq` is low.
- R2: The configuration word of line n sits at byte address 4*n (n = 0..63). Bits 6:0 take the written data. Bits 31:7 always read as zero.
- R3: A line is enabled only when its 7-bit field equals the enable code: 0x51 in flavor A (default) and 0x20 in flavor B. Any other value, including 0x00, 0x50 and 0x52, disables the line.
- R4: The select word is at byte address 0x10C in flavor A and 0x104 in flavor B. Bit 6 is the pending flag, bits 5:0 are the line number, and bits 31:7 read zero.
- R5: When several enabled lines are high together, the select word reports the lowest-numbered one.
- R6: When no enabled line is high, the whole select word reads zero.
- R7: Lines are level-sensitive, with no acknowledge. When the input drops, the line stops being reported on the next clock edge without any register access.
- R8: `cpu_irq` equals the select word's pending flag. It changes on the first clock edge after an input changes. After a configuration write, it changes on the edge that follows the write edge.
- R9: The select word is read-only. A write to it changes neither the select word nor any configuration field.
- R10: Addresses outside the configuration words and the select word read as zero, and writes to them change no configuration field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 64 | Level interrupt lines, bit n is line n |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cpu_irq | output | 1 | Registered request to the processor |

## Verification
Read data is combinational, so a configuration word holds its new value from the write edge onward and can be read 1 ns later. The select word and `cpu_irq` lag by one register. A line change applied at a falling edge shows up 1 ns after the next rising edge. A configuration write shows up one further edge later. The bench checks the old value just before each due edge and the new value just after it. It never samples at an edge.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int NUM_SRC = 64;
    localparam int CFG_W   = 7;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 12;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int WORD_W  = ADDR_W - 2;

    typedef enum logic {
        FLAVOR_A = 1'b0,
        FLAVOR_B = 1'b1
    } flavor_e;

    // Packed select word: pending flag above the line number
    typedef struct packed {
        logic             pend;
        logic [IDX_W-1:0] idx;
    } sel_t;

    // One configuration write request
    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] idx;
        logic [CFG_W-1:0] data;
    } cfg_wr_t;

    function automatic logic [CFG_W-1:0] enable_code(flavor_e f);
        return (f == FLAVOR_A) ? 7'h51 : 7'h20;
    endfunction

    function automatic logic [ADDR_W-1:0] sel_offset(flavor_e f);
        return (f == FLAVOR_A) ? 12'h10C : 12'h104;
    endfunction

endpackage

// File: rtl/irqv_cfg_bank.sv
module irqv_cfg_bank
    import irqv_pkg::*;
#(
    parameter logic [CFG_W-1:0] EN_CODE = 7'h51
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_wr_t          cfg_wr,
    output logic [CFG_W-1:0] cfg_q [NUM_SRC],
    output logic [NUM_SRC-1:0] en_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [CFG_W-1:0] field_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                field_q <= '0;
            end else if (cfg_wr.we && (cfg_wr.idx == IDX_W'(g))) begin
                field_q <= cfg_wr.data;
            end
        end

        assign cfg_q[g] = field_q;
        assign en_o[g]  = (field_q == EN_CODE);
    end

endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc
    import irqv_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output sel_t               pick
);

    always_comb begin
        pick = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.pend = 1'b1;
                pick.idx  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqv_regif.sv
module irqv_regif
    import irqv_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SEL_ADDR = 12'h10C
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic [CFG_W-1:0]  cfg_q [NUM_SRC],
    input  sel_t              sel_q,
    output cfg_wr_t           cfg_wr,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [WORD_W-1:0] CFG_WORDS = WORD_W'(NUM_SRC);
    localparam logic [WORD_W-1:0] SEL_WORD  = SEL_ADDR[ADDR_W-1:2];

    logic [WORD_W-1:0] word;
    logic              hit_cfg;
    logic              hit_sel;
    logic              unused_bits;

    assign word    = addr[ADDR_W-1:2];
    assign hit_cfg = (word < CFG_WORDS);
    assign hit_sel = (word == SEL_WORD);

    assign cfg_wr.we   = we & hit_cfg;
    assign cfg_wr.idx  = word[IDX_W-1:0];
    assign cfg_wr.data = wdata[CFG_W-1:0];

    always_comb begin
        rdata = '0;
        if (hit_cfg) begin
            rdata[CFG_W-1:0] = cfg_q[word[IDX_W-1:0]];
        end else if (hit_sel) begin
            rdata[IDX_W:0] = sel_q;
        end
    end

    assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:CFG_W]};

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter flavor_e FLAVOR = FLAVOR_A
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic               reg_we,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               cpu_irq
);

    localparam logic [CFG_W-1:0]  EN_CODE  = enable_code(FLAVOR);
    localparam logic [ADDR_W-1:0] SEL_ADDR = sel_offset(FLAVOR);

    cfg_wr_t             cfg_wr;
    logic [CFG_W-1:0]    cfg_q [NUM_SRC];
    logic [NUM_SRC-1:0]  en;
    logic [NUM_SRC-1:0]  req;
    sel_t                pick;
    sel_t                sel_q;

    irqv_regif #(
        .SEL_ADDR (SEL_ADDR)
    ) u_regif (
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .we     (reg_we),
        .cfg_q  (cfg_q),
        .sel_q  (sel_q),
        .cfg_wr (cfg_wr),
        .rdata  (reg_rdata)
    );

    irqv_cfg_bank #(
        .EN_CODE (EN_CODE)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_wr (cfg_wr),
        .cfg_q  (cfg_q),
        .en_o   (en)
    );

    assign req = src_i & en;

    irqv_prio_enc u_prio (
        .req  (req),
        .pick (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else begin
            sel_q <= pick;
        end
    end

    assign cpu_irq = sel_q.pend;

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
    import irqv_pkg::*;
#(
    parameter flavor_e FLAVOR = FLAVOR_A
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_i,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               cpu_irq
);

    localparam logic [ADDR_W-1:0] SEL_A = sel_offset(FLAVOR);

    logic [NUM_SRC-1:0] src_q;
    logic               at_sel;
    logic               at_cfg;

    always_ff @(posedge clk) begin
        src_q <= src_i;
    end

    assign at_sel = (reg_addr == SEL_A);
    assign at_cfg = (reg_addr[ADDR_W-1:2] < WORD_W'(NUM_SRC));

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !cpu_irq);

    p_cfg_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        at_cfg |-> (reg_rdata[DATA_W-1:CFG_W] == '0));

    p_sel_flag_r8: assert property (@(posedge clk) disable iff (rst)
        at_sel |-> (reg_rdata[IDX_W] == cpu_irq));

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (at_sel && !cpu_irq) |-> (reg_rdata == '0));

    p_irq_needs_src_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> $past(|src_i));

    p_pick_was_high_r5: assert property (@(posedge clk) disable iff (rst)
        (at_sel && cpu_irq) |-> src_q[reg_rdata[IDX_W-1:0]]);

endmodule

bind irq_vector_ctrl irqv_checker #(.FLAVOR(FLAVOR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .cpu_irq   (cpu_irq)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    import irqv_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [63:0]       src = '0;
    logic [11:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic              we = 1'b0;
    logic [31:0]       rdata, rdata_alt;
    logic              irq, irq_alt;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst(rst), .src_i(src), .reg_addr(addr),
        .reg_wdata(wdata), .reg_we(we), .reg_rdata(rdata), .cpu_irq(irq)
    );

    irq_vector_ctrl #(.FLAVOR(FLAVOR_B)) u_dut_alt (
        .clk(clk), .rst(rst), .src_i(src), .reg_addr(addr),
        .reg_wdata(wdata), .reg_we(we), .reg_rdata(rdata_alt), .cpu_irq(irq_alt)
    );

    localparam logic [11:0] SEL_A = 12'h10C;
    localparam logic [11:0] SEL_B = 12'h104;

    // {line pattern, expected select word} with lines 3,10,31,32,63 enabled
    localparam int NV = 10;
    localparam logic [70:0] VEC [NV] = '{
        {64'h0000_0000_0000_0000, 7'h00},
        {64'h0000_0000_0000_0008, 7'h43},
        {64'h0000_0000_0000_0020, 7'h00},
        {64'h0000_0000_8000_0400, 7'h4A},
        {64'h8000_0000_0000_0000, 7'h7F},
        {64'h8000_0001_0000_0000, 7'h60},
        {64'hFFFF_FFFF_FFFF_FFFF, 7'h43},
        {64'h0000_0000_0000_0080, 7'h00},
        {64'h8000_0000_0000_00A0, 7'h7F},
        {64'h0000_0001_8000_0000, 7'h5F}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        #1;
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        addr = a;
        #1;
    endtask

    task automatic set_src(input logic [63:0] s);
        @(negedge clk);
        src = s;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(12'h000); chk("R1 cfg0", rdata, 32'd0);
        rd(12'h094); chk("R1 cfg37", rdata, 32'd0);
        rd(12'h0FC); chk("R1 cfg63", rdata, 32'd0);
        rd(SEL_A);   chk("R1 select", rdata, 32'd0);

        // R2: field width and placement
        wr(12'h030, 32'hFFFF_FFFF);
        rd(12'h030); chk("R2 cfg12 masked", rdata, 32'h7F);
        rd(12'h02C); chk("R2 cfg11 untouched", rdata, 32'd0);
        wr(12'h030, 32'd0);

        // table setup: enabled 3,10,31,32,63; 5 wrong code, 7 near miss (R3)
        wr(12'h00C, 32'h51);
        wr(12'h028, 32'h51);
        wr(12'h07C, 32'h51);
        wr(12'h080, 32'h51);
        wr(12'h0FC, 32'h51);
        wr(12'h014, 32'h20);
        wr(12'h01C, 32'h50);
        rd(12'h0FC); chk("R2 cfg63 readback", rdata, 32'h51);
        rd(SEL_A);
        tick();

        // table walk: R3 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            logic prev;
            prev = irq;
            set_src(VEC[i][70:7]);
            #1;
            chk("R8 irq holds before edge", {31'd0, irq}, {31'd0, prev});
            tick();
            chk("R5 select word", rdata, {25'd0, VEC[i][6:0]});
            chk("R8 irq follows flag", {31'd0, irq}, {31'd0, VEC[i][6]});
        end

        // R9: select word read-only, no alias into cfg3
        set_src(64'd0);
        wr(SEL_A, 32'hFFFF_FFFF);
        tick();
        rd(SEL_A);   chk("R9 select after write", rdata, 32'd0);
        rd(12'h00C); chk("R9 cfg3 kept", rdata, 32'h51);
        set_src(64'h8);
        tick();
        rd(SEL_A);   chk("R9 select still live", rdata, 32'h43);
        set_src(64'd0);
        tick();

        // R10: unmapped space
        wr(12'h200, 32'h51);
        rd(12'h200); chk("R10 unmapped read", rdata, 32'd0);
        rd(12'h000); chk("R10 cfg0 untouched", rdata, 32'd0);

        // R3 / R8: config write timing with line 20 high
        set_src(64'h0010_0000);
        tick();
        chk("R3 zero field disables", {31'd0, irq}, 32'd0);
        wr(12'h050, 32'h51);
        chk("R8 irq not yet after write edge", {31'd0, irq}, 32'd0);
        tick();
        chk("R8 irq one edge after write", {31'd0, irq}, 32'd1);
        rd(SEL_A); chk("R4 select line 20", rdata, 32'h54);

        // R3: other code disables again
        wr(12'h050, 32'h52);
        tick();
        chk("R3 code 0x52 disables", {31'd0, irq}, 32'd0);
        wr(12'h050, 32'h51);
        tick();
        chk("R3 re-enabled", {31'd0, irq}, 32'd1);

        // R7: level drop clears without access
        set_src(64'd0);
        tick();
        chk("R7 irq drops", {31'd0, irq}, 32'd0);
        rd(SEL_A); chk("R7 select clear", rdata, 32'd0);

        // R3 / R4: flavor B code and select address
        set_src(64'h200);
        wr(12'h024, 32'h20);
        tick();
        chk("R3 flavor A rejects 0x20", {31'd0, irq}, 32'd0);
        chk("R3 flavor B accepts 0x20", {31'd0, irq_alt}, 32'd1);
        rd(SEL_B);
        chk("R4 flavor B select", rdata_alt, 32'h49);
        chk("R10 flavor A 0x104 unmapped", rdata, 32'd0);
        rd(SEL_A);
        chk("R10 flavor B 0x10C unmapped", rdata_alt, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule